// File: doc/BRIEF.md
# Multi-Pixel Sliding Window Line Buffer

This block sits in a streaming image pipeline and turns a stream of pixel beats into a sliding window along one image row. Each beat carries a fixed number of pixels side by side. The window is several beats wide. The block keeps the most recent accepted beats in a short register chain. It joins that chain with the beat currently on its input, so the newest pixels reach the window in the same cycle they are presented.

An enable input acts as a clock enable. A cycle with the enable low neither stores pixels nor moves the row position. The block counts accepted beats within a row of fixed length. Its window-valid output rises only once every stored slot of the window holds a pixel from the current row. At the end of each row the count starts over, so the warmup repeats.

A second status output reports whether the stored chain is full, whatever the enable does. Downstream logic normally leaves this output unconnected. A build parameter decides whether window-valid is generated at all. When it is not generated, the port stays in the port list and is held low.

Top module: `mpx_window_buffer`

## Requirements
- R1: Window slot `s` occupies bits `[s*PIX_W +: PIX_W]` of `win_out`, and slot 0 is the oldest pixel. Slots `HIST*P` to `W-1` carry the current input beat with no register delay. Input pixel `j` sits at bits `[j*PIX_W +: PIX_W]` of `pix_in` and goes to slot `HIST*P+j`. Here `HIST = W/P - 1`.
- R2: For a stored beat `b < HIST`, slot `b*P+j` holds pixel `j` of the beat accepted `HIST-b` accepted beats earlier.
- R3: While `en` is low, no beat is stored and the row position holds. The stored part of the window is therefore unchanged on the next cycle.
- R4: With `HAS_VALID=1`, `win_valid` is high exactly when `en` is high and at least `HIST` beats have been accepted since the current row began. With P=2 and W=4, it is low on the first accepted beat of a row and high from the second onward.
- R5: With `HAS_VALID=0`, `win_valid` is held low.
- R6: `chain_valid` is high exactly when at least `HIST` beats have been accepted in the current row, independent of `en`.
- R7: After `ROW_PIX/P` accepted beats the row position returns to the row start. The first `HIST` accepted beats of the new row are reported invalid.
- R8: A synchronous reset (`rst` high at a clock edge) clears every stored pixel to zero and returns the row position to the start. After the reset, `chain_valid` and `win_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Beat accept / clock enable |
| pix_in | input | PIX_PER_BEAT*PIX_W | Current beat, pixel 0 in the low bits |
| win_out | output | WIN_PIX*PIX_W | Window, oldest pixel in the low bits |
| win_valid | output | 1 | Window complete and current beat accepted |
| chain_valid | output | 1 | Stored chain full for the current row |

## Verification
The bench runs two configurations side by side: a one-beat chain over a 15-beat row, and a two-beat chain over a 4-beat row with window-valid disabled. These cover row wraps many times over. The enable is driven steadily, toggled on alternate cycles, and driven in an irregular pattern.

Each kind of fault shows up at the ports in a specific way:
- A design that advanced its history or row position on idle cycles would show stale or skipped pixels in the stored slots, and valid rising early under the toggling enable.
- Registering the newest slice would put the current beat one cycle late.
- Slots in reversed order would swap the oldest and newest pixels.
- Forgetting to restart warmup at a row boundary would leave valid high on the first beat of a row.

// File: rtl/mpxwb_pkg.sv
package mpxwb_pkg;

  // number of beats kept in the register chain
  function automatic int hist_beats(input int win_pix, input int ppb);
    return (win_pix / ppb) - 1;
  endfunction

  // accepted beats that make up one row
  function automatic int row_beats(input int row_pix, input int ppb);
    return row_pix / ppb;
  endfunction

  // counter width able to hold 0 .. n-1
  function automatic int cnt_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/mpxwb_rowpos.sv
module mpxwb_rowpos #(
  parameter int ROW_BEATS = 15,
  parameter int HIST      = 1,
  parameter int CW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [CW-1:0] pos,
  output logic          wrap,
  output logic          warm
);
  localparam logic [CW-1:0] LAST   = CW'(ROW_BEATS - 1);
  localparam logic [CW:0]   HIST_V = (CW+1)'(HIST);

  assign wrap = adv && (pos == LAST);
  assign warm = ({1'b0, pos} >= HIST_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (adv) begin
      if (pos == LAST) pos <= '0;
      else             pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/mpxwb_history.sv
module mpxwb_history #(
  parameter int BEAT_W = 16,
  parameter int HIST   = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift,
  input  logic [BEAT_W-1:0]      din,
  output logic [HIST*BEAT_W-1:0] hist_flat
);
  // slice 0 is the oldest beat, slice HIST-1 the most recent
  for (genvar k = 0; k < HIST; k++) begin : g_stage
    logic [BEAT_W-1:0] nxt;
    if (k == HIST - 1) begin : g_tail
      assign nxt = din;
    end else begin : g_mid
      assign nxt = hist_flat[(k+1)*BEAT_W +: BEAT_W];
    end
    always_ff @(posedge clk) begin
      if (rst)        hist_flat[k*BEAT_W +: BEAT_W] <= '0;
      else if (shift) hist_flat[k*BEAT_W +: BEAT_W] <= nxt;
    end
  end
endmodule

// File: rtl/mpxwb_assemble.sv
module mpxwb_assemble #(
  parameter int BEAT_W = 16,
  parameter int HIST   = 1
) (
  input  logic [HIST*BEAT_W-1:0]     hist_flat,
  input  logic [BEAT_W-1:0]          cur,
  output logic [(HIST+1)*BEAT_W-1:0] win
);
  for (genvar b = 0; b <= HIST; b++) begin : g_slot
    if (b == HIST) begin : g_cur
      assign win[b*BEAT_W +: BEAT_W] = cur;
    end else begin : g_old
      assign win[b*BEAT_W +: BEAT_W] = hist_flat[b*BEAT_W +: BEAT_W];
    end
  end
endmodule

// File: rtl/mpx_window_buffer.sv
module mpx_window_buffer #(
  parameter int PIX_W        = 8,
  parameter int PIX_PER_BEAT = 2,
  parameter int WIN_PIX      = 4,
  parameter int ROW_PIX      = 30,
  parameter bit HAS_VALID    = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            en,
  input  logic [PIX_PER_BEAT*PIX_W-1:0]   pix_in,
  output logic [WIN_PIX*PIX_W-1:0]        win_out,
  output logic                            win_valid,
  output logic                            chain_valid
);
  import mpxwb_pkg::*;

  localparam int BEAT_W    = PIX_PER_BEAT * PIX_W;
  localparam int HIST      = hist_beats(WIN_PIX, PIX_PER_BEAT);
  localparam int ROW_BEATS = row_beats(ROW_PIX, PIX_PER_BEAT);
  localparam int CW        = cnt_bits(ROW_BEATS);

  // named internal events
  logic                   beat_accept;
  logic                   row_wrap;
  logic                   hist_full;
  logic [CW-1:0]          row_pos;
  logic [HIST*BEAT_W-1:0] hist_flat;

  assign beat_accept = en;

  mpxwb_rowpos #(.ROW_BEATS(ROW_BEATS), .HIST(HIST), .CW(CW)) u_pos (
    .clk(clk), .rst(rst), .adv(beat_accept),
    .pos(row_pos), .wrap(row_wrap), .warm(hist_full)
  );

  mpxwb_history #(.BEAT_W(BEAT_W), .HIST(HIST)) u_hist (
    .clk(clk), .rst(rst), .shift(beat_accept),
    .din(pix_in), .hist_flat(hist_flat)
  );

  mpxwb_assemble #(.BEAT_W(BEAT_W), .HIST(HIST)) u_asm (
    .hist_flat(hist_flat), .cur(pix_in), .win(win_out)
  );

  assign chain_valid = hist_full;

  if (HAS_VALID) begin : g_valid
    assign win_valid = beat_accept & hist_full;
  end else begin : g_novalid
    assign win_valid = 1'b0;
  end
endmodule

// File: rtl/mpxwb_chk.sv
module mpxwb_chk #(
  parameter int PIX_W        = 8,
  parameter int PIX_PER_BEAT = 2,
  parameter int WIN_PIX      = 4,
  parameter bit HAS_VALID    = 1'b1,
  parameter int CW           = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          en,
  input logic [PIX_PER_BEAT*PIX_W-1:0] pix_in,
  input logic [WIN_PIX*PIX_W-1:0]      win_out,
  input logic                          win_valid,
  input logic                          chain_valid,
  input logic [CW-1:0]                 row_pos,
  input logic                          row_wrap
);
  localparam int BEAT_W = PIX_PER_BEAT * PIX_W;
  localparam int HIST   = WIN_PIX / PIX_PER_BEAT - 1;

  AST_NEWEST_LIVE: assert property (@(posedge clk) disable iff (rst)
    win_out[HIST*BEAT_W +: BEAT_W] == pix_in); // R1

  AST_LAST_STORED: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst)) |-> win_out[(HIST-1)*BEAT_W +: BEAT_W] == $past(pix_in)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(rst)) |=> ($stable(row_pos) && $stable(win_out[HIST*BEAT_W-1:0]))); // R3

  AST_VALID_GATED: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (en && chain_valid)); // R4

  AST_VALID_OFF: assert property (@(posedge clk) disable iff (rst)
    !HAS_VALID |-> !win_valid); // R5

  AST_ROW_RESTART: assert property (@(posedge clk) disable iff (rst)
    row_wrap |=> (row_pos == '0) && !chain_valid); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (row_pos == '0) && !chain_valid && !win_valid); // R8
endmodule

bind mpx_window_buffer mpxwb_chk #(
  .PIX_W(PIX_W), .PIX_PER_BEAT(PIX_PER_BEAT), .WIN_PIX(WIN_PIX),
  .HAS_VALID(HAS_VALID), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .pix_in(pix_in), .win_out(win_out),
  .win_valid(win_valid), .chain_valid(chain_valid),
  .row_pos(row_pos), .row_wrap(row_wrap)
);

// File: tb/sim_mpx_window_buffer.sv
module sim_mpx_window_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int ROWB0 = 15;   // 30 px / 2
  localparam int ROWB1 = 4;    // 8 px / 2

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [15:0] pix = '0;
  logic [31:0] win0;
  logic [47:0] win1;
  logic        val0, val1, ch0, ch1;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench model
  logic [15:0] mh_new = '0, mh_old = '0;
  int pos0 = 0, pos1 = 0;
  bit prev_en = 1'b0;
  bit first_after_rst = 1'b0;
  int seq = 0;
  logic [7:0] lfsr = 8'h5a;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpx_window_buffer #(.PIX_W(8), .PIX_PER_BEAT(2), .WIN_PIX(4), .ROW_PIX(30), .HAS_VALID(1'b1)) u0 (
    .clk(clk), .rst(rst), .en(en), .pix_in(pix),
    .win_out(win0), .win_valid(val0), .chain_valid(ch0));

  mpx_window_buffer #(.PIX_W(8), .PIX_PER_BEAT(2), .WIN_PIX(6), .ROW_PIX(8), .HAS_VALID(1'b0)) u1 (
    .clk(clk), .rst(rst), .en(en), .pix_in(pix),
    .win_out(win1), .win_valid(val1), .chain_valid(ch1));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit e);
    @(negedge clk);
    rst = r;
    en  = e;
    pix = {8'(seq*2 + 2), 8'(seq*2 + 1)};
    seq++;
    #1;
    if (!r) begin
      if (first_after_rst) begin
        chk("R8 chain after reset", 64'(ch0), 64'(0));
        chk("R8 history cleared", 64'(win0[15:0]), 64'(0));
        first_after_rst = 1'b0;
      end
      chk("R1 current slice", 64'(win0[31:16]), 64'(pix));
      chk(prev_en ? "R2 stored slice" : "R3 stored slice after idle", 64'(win0[15:0]), 64'(mh_new));
      chk("R2 two-beat chain", 64'(win1), 64'({pix, mh_new, mh_old}));
      chk("R4 valid", 64'(val0), 64'(e && pos0 >= 1));
      chk("R5 valid disabled", 64'(val1), 64'(0));
      chk(pos0 == 0 ? "R7 chain at row start" : "R6 chain", 64'(ch0), 64'(pos0 >= 1));
      chk(pos1 == 0 ? "R7 chain1 at row start" : "R6 chain1", 64'(ch1), 64'(pos1 >= 2));
    end
    @(posedge clk);
    if (r) begin
      mh_new = '0; mh_old = '0; pos0 = 0; pos1 = 0;
      first_after_rst = 1'b1;
    end else if (e) begin
      mh_old = mh_new; mh_new = pix;
      pos0 = (pos0 + 1) % ROWB0;
      pos1 = (pos1 + 1) % ROWB1;
    end
    prev_en = e && !r;
  endtask

  initial begin
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 60; i++) step(1'b0, (i % 2) == 0);
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(1'b0, lfsr[0]);
    end
    step(1'b1, 1'b1);
    for (int i = 0; i < 35; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 30; i++) step(1'b0, (i % 3) != 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule